// File: doc/BRIEF.md
# External Pin Interrupt Detector

This block watches up to 24 external pins and turns their activity into interrupt requests. Each pin is first synchronised into the clock domain. A trigger code then selects one of five types: low level, high level, falling edge, rising edge or both edges. A pin can request only while its pin-function field selects interrupt mode.

Pins 0 to 3 are direct sources. Each has a request output of its own, registered and never masked. Pins 4 to 23 set bits in a pending register, which software clears by writing ones. A mask register gates these bits into two combined parent requests: one for pins 4 to 7 and one for pins 8 to 23. The upstream controller that consumes these requests sits outside this block.

The configuration inputs (trigger codes and pin functions) come from a register file elsewhere and are plain levels. The mask write and the pending clear are single-cycle strobes with no back-pressure. A write is accepted in the cycle its enable is high.

Top module: `ext_pin_irq_detect`

## Requirements
- R1: Trigger code (3 bits) selects the type: 000 low level, 001 high level, 010/011 falling edge, 100/101 rising edge, 110/111 both edges. Edge types compare the synchronised pin value with its value one cycle earlier.
- R2: The trigger code of pin p sits in trig_cfg bits [4p+2:4p]. This is word p/8, bit 4×(p mod 8), with three 32-bit words packed low word first. Bit 4p+3 is ignored.
- R3: A pin whose 2-bit field pin_func[2p+1:2p] is not 2 never raises a pending bit or a direct request.
- R4: A pin change present at clock edge k is reflected in pend_q and direct_req after edge k+2.
- R5: For pins 4 to 23, a detected event sets the pending bit. A pend_clr_en strobe clears each bit written as 1. An event in the same cycle as a clear wins.
- R6: For level types, the pending bit is set again on every cycle the level stays active. A clear therefore has no lasting effect until the level goes away.
- R7: A mask bit of 1 keeps its pending bit out of the parent request. The pending bit itself still latches.
- R8: parent_lo is high when any of pend_q[7:4] is high with its mask bit 0. parent_hi is the same for bits 23 to 8.
- R9: direct_req[i] for pins 0 to 3 is high for each cycle after a cycle in which pin i had a detected event. Edge types give a one-cycle pulse. The mask has no effect on it.
- R10: Bits 3 to 0 of pend_q and mask_q always read 0, and writes to them have no effect.
- R11: After reset, mask_q bits 23 to 4 are 1, pend_q is 0, and all requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 24 | Asynchronous external pins |
| pin_func | input | 48 | 2-bit function field per pin; 2 selects interrupt mode |
| trig_cfg | input | 96 | Three trigger-configuration words, 4-bit stride per pin |
| mask_wr_en | input | 1 | Load mask_wr_data into the mask register |
| mask_wr_data | input | 24 | New mask value |
| pend_clr_en | input | 1 | Write-one-to-clear strobe for pending bits |
| pend_clr_data | input | 24 | Bits to clear |
| pend_q | output | 24 | Pending register |
| mask_q | output | 24 | Mask register |
| direct_req | output | 4 | Requests of pins 0 to 3 |
| parent_lo | output | 1 | Combined request of pins 4 to 7 |
| parent_hi | output | 1 | Combined request of pins 8 to 23 |

## Verification
A pin change takes two register stages to reach the detector. Pending bits and direct requests therefore move after the third clock edge following the input change. The parent requests follow pending and mask with no added stage. Mask writes and clears act on the next edge. The bench drives inputs on the falling edge and checks on the falling edge. Directed checks are placed at the edge count where a result is due and also one edge earlier, where it must still be absent. A behavioural model running the same edge arithmetic is compared with every output on every cycle.

// File: rtl/epi_pkg.sv
package epi_pkg;
  localparam logic [1:0] FUNC_IRQ = 2'b10;
  localparam int CODE_W   = 3;
  localparam int CODE_STR = 4;

  // Decide whether a pin fires this cycle for a given trigger code.
  function automatic logic trig_hit(input logic [2:0] code, input logic cur, input logic old);
    logic hit;
    casez (code)
      3'b000:  hit = !cur;
      3'b001:  hit = cur;
      3'b01?:  hit = old && !cur;
      3'b10?:  hit = !old && cur;
      default: hit = old ^ cur;
    endcase
    return hit;
  endfunction
endpackage

// File: rtl/epi_sync.sv
module epi_sync #(
  parameter int WIDTH  = 24,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/epi_detect.sv
module epi_detect
  import epi_pkg::*;
#(
  parameter int NUM_PINS = 24
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          sync_pin,
  input  logic [2*NUM_PINS-1:0]        pin_func,
  input  logic [CODE_STR*NUM_PINS-1:0] trig_cfg,
  output logic [NUM_PINS-1:0]          evt
);
  logic [NUM_PINS-1:0] last_pin;
  logic [NUM_PINS-1:0] unused_spare;

  always_ff @(posedge clk) begin
    if (!rst_n) last_pin <= '0;
    else last_pin <= sync_pin;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CODE_W-1:0] code;
    logic              armed;
    assign code            = trig_cfg[CODE_STR*p +: CODE_W];
    assign unused_spare[p] = trig_cfg[CODE_STR*p + CODE_W];
    assign armed           = (pin_func[2*p +: 2] == FUNC_IRQ);
    assign evt[p]          = armed && trig_hit(code, sync_pin[p], last_pin[p]);
  end
endmodule

// File: rtl/epi_pend.sv
module epi_pend #(
  parameter int NUM_PINS   = 24,
  parameter int LOW_FIRST  = 4,
  parameter int HIGH_FIRST = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] evt,
  input  logic                mask_wr_en,
  input  logic [NUM_PINS-1:0] mask_wr_data,
  input  logic                clr_en,
  input  logic [NUM_PINS-1:0] clr_data,
  output logic [NUM_PINS-1:0] pend_q,
  output logic [NUM_PINS-1:0] mask_q,
  output logic                parent_lo,
  output logic                parent_hi
);
  logic [3*LOW_FIRST-1:0] unused_low;
  assign unused_low = {evt[LOW_FIRST-1:0], mask_wr_data[LOW_FIRST-1:0], clr_data[LOW_FIRST-1:0]};

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
    if (i < LOW_FIRST) begin : g_none
      assign pend_q[i] = 1'b0;
      assign mask_q[i] = 1'b0;
    end else begin : g_reg
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q[i] <= 1'b0;
          mask_q[i] <= 1'b1;
        end else begin
          pend_q[i] <= evt[i] | (pend_q[i] & ~(clr_en & clr_data[i]));
          if (mask_wr_en) mask_q[i] <= mask_wr_data[i];
        end
      end
    end
  end

  assign parent_lo = |(pend_q[HIGH_FIRST-1:LOW_FIRST] & ~mask_q[HIGH_FIRST-1:LOW_FIRST]);
  assign parent_hi = |(pend_q[NUM_PINS-1:HIGH_FIRST] & ~mask_q[NUM_PINS-1:HIGH_FIRST]);
endmodule

// File: rtl/ext_pin_irq_detect.sv
module ext_pin_irq_detect
  import epi_pkg::*;
#(
  parameter int NUM_PINS    = 24,
  parameter int DIRECT_PINS = 4,
  parameter int HIGH_FIRST  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PINS-1:0]          pin_in,
  input  logic [2*NUM_PINS-1:0]        pin_func,
  input  logic [CODE_STR*NUM_PINS-1:0] trig_cfg,
  input  logic                         mask_wr_en,
  input  logic [NUM_PINS-1:0]          mask_wr_data,
  input  logic                         pend_clr_en,
  input  logic [NUM_PINS-1:0]          pend_clr_data,
  output logic [NUM_PINS-1:0]          pend_q,
  output logic [NUM_PINS-1:0]          mask_q,
  output logic [DIRECT_PINS-1:0]       direct_req,
  output logic                         parent_lo,
  output logic                         parent_hi
);
  logic [NUM_PINS-1:0] sync_pin;
  logic [NUM_PINS-1:0] evt;

  epi_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(sync_pin)
  );

  epi_detect #(.NUM_PINS(NUM_PINS)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin),
    .pin_func(pin_func), .trig_cfg(trig_cfg), .evt(evt)
  );

  epi_pend #(.NUM_PINS(NUM_PINS), .LOW_FIRST(DIRECT_PINS), .HIGH_FIRST(HIGH_FIRST)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .clr_en(pend_clr_en), .clr_data(pend_clr_data),
    .pend_q(pend_q), .mask_q(mask_q),
    .parent_lo(parent_lo), .parent_hi(parent_hi)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) direct_req <= '0;
    else direct_req <= evt[DIRECT_PINS-1:0];
  end
endmodule

// File: rtl/epi_checker.sv
module epi_checker #(
  parameter int NUM_PINS    = 24,
  parameter int DIRECT_PINS = 4,
  parameter int HIGH_FIRST  = 8
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [2*NUM_PINS-1:0]  pin_func,
  input logic [NUM_PINS-1:0]    evt,
  input logic                   pend_clr_en,
  input logic [NUM_PINS-1:0]    pend_clr_data,
  input logic [NUM_PINS-1:0]    pend_q,
  input logic [NUM_PINS-1:0]    mask_q,
  input logic [DIRECT_PINS-1:0] direct_req,
  input logic                   parent_lo,
  input logic                   parent_hi
);
  localparam logic [NUM_PINS-1:0] PEND_BITS = {NUM_PINS{1'b1}} << DIRECT_PINS;

  logic [NUM_PINS-1:0] armed;
  logic [NUM_PINS-1:0] clr_live;
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_arm
    assign armed[p] = (pin_func[2*p +: 2] == 2'b10);
  end
  assign clr_live = (pend_clr_en ? pend_clr_data : '0) & ~evt & PEND_BITS;

  // R5: a cleared bit with no event in that cycle reads 0 afterwards
  a_r5_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_live != '0) |=> ((pend_q & $past(clr_live)) == '0));

  // R5: an event always leaves its pending bit set, even against a clear
  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & PEND_BITS) != '0) |=> ((pend_q & $past(evt & PEND_BITS)) == $past(evt & PEND_BITS)));

  // R3: a direct request only follows a cycle where the pin was armed
  a_r3_direct_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((direct_req & ~$past(armed[DIRECT_PINS-1:0])) == '0));

  // R3: no event from a pin outside interrupt mode
  a_r3_evt_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~armed) == '0));

  // R7: fully masked groups stay quiet
  a_r7_low_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[HIGH_FIRST-1:DIRECT_PINS]) |-> !parent_lo);
  a_r7_high_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q[NUM_PINS-1:HIGH_FIRST]) |-> !parent_hi);
endmodule

bind ext_pin_irq_detect epi_checker #(
  .NUM_PINS(NUM_PINS), .DIRECT_PINS(DIRECT_PINS), .HIGH_FIRST(HIGH_FIRST)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_func(pin_func), .evt(evt),
  .pend_clr_en(pend_clr_en), .pend_clr_data(pend_clr_data),
  .pend_q(pend_q), .mask_q(mask_q), .direct_req(direct_req),
  .parent_lo(parent_lo), .parent_hi(parent_hi)
);

// File: tb/test_ext_pin_irq_detect.sv
module test_ext_pin_irq_detect;
  localparam int CLK_PERIOD = 10;
  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_in = '0;
  logic [2*N-1:0] pin_func = '0;
  logic [4*N-1:0] trig_cfg = '0;
  logic          mask_wr_en = 1'b0;
  logic [N-1:0]  mask_wr_data = '0;
  logic          pend_clr_en = 1'b0;
  logic [N-1:0]  pend_clr_data = '0;
  logic [N-1:0]  pend_q, mask_q;
  logic [3:0]    direct_req;
  logic          parent_lo, parent_hi;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_pin_irq_detect i_ext_pin_irq_detect (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_func(pin_func), .trig_cfg(trig_cfg),
    .mask_wr_en(mask_wr_en), .mask_wr_data(mask_wr_data),
    .pend_clr_en(pend_clr_en), .pend_clr_data(pend_clr_data),
    .pend_q(pend_q), .mask_q(mask_q), .direct_req(direct_req),
    .parent_lo(parent_lo), .parent_hi(parent_hi)
  );

  // Behavioural reference model
  bit [N-1:0] m_s1, m_s2, m_old, m_pend;
  bit [N-1:0] m_mask = 24'hFFFFF0;
  bit [3:0]   m_direct;

  function automatic bit fires(int code, bit cur, bit old);
    if (code == 0) return !cur;
    if (code == 1) return cur;
    if (code < 4)  return old && !cur;
    if (code < 6)  return !old && cur;
    return old != cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_old = '0; m_pend = '0; m_mask = 24'hFFFFF0; m_direct = '0;
    end else begin
      for (int p = 0; p < N; p++) begin
        bit ev;
        ev = (pin_func[2*p +: 2] == 2'd2) && fires(int'(trig_cfg[4*p +: 3]), m_s2[p], m_old[p]);
        if (p < 4) m_direct[p] = ev;
        else begin
          if (pend_clr_en && pend_clr_data[p]) m_pend[p] = 1'b0;
          if (ev) m_pend[p] = 1'b1;
          if (mask_wr_en) m_mask[p] = mask_wr_data[p];
        end
      end
      m_old = m_s2; m_s2 = m_s1; m_s1 = pin_in;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [N-1:0] live;
      live = m_pend & ~m_mask;
      total++;
      if ({pend_q, mask_q, direct_req, parent_lo, parent_hi} !==
          {m_pend, m_mask, m_direct, |live[7:4], |live[23:8]}) begin
        bad++;
        $display("FAIL R8 model: got pend=%h mask=%h dir=%b lo=%b hi=%b exp pend=%h mask=%h dir=%b lo=%b hi=%b",
                 pend_q, mask_q, direct_req, parent_lo, parent_hi,
                 m_pend, m_mask, m_direct, |live[7:4], |live[23:8]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_pin(input int p, input bit [1:0] f, input bit [2:0] code);
    pin_func[2*p +: 2] = f;
    trig_cfg[4*p +: 3] = code;
  endtask

  task automatic wr_mask(input logic [N-1:0] v);
    mask_wr_en = 1'b1; mask_wr_data = v; cyc(1); mask_wr_en = 1'b0;
  endtask

  task automatic clr(input logic [N-1:0] v);
    pend_clr_en = 1'b1; pend_clr_data = v; cyc(1); pend_clr_en = 1'b0; pend_clr_data = '0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11 mask", mask_q, 24'hFFFFF0);
    chk("R11 pend", pend_q, 0);
    chk("R11 reqs", {direct_req, parent_lo, parent_hi}, 0);

    // R2 R4 R8: pin 5 rising, word 0 field at bits 22:20
    set_pin(5, 2, 3'b100);
    wr_mask(24'hFFFFD0);
    pin_in[5] = 1'b1;
    cyc(2);
    chk("R4 not yet", pend_q[5], 0);
    cyc(1);
    chk("R4 pend after 3 edges", pend_q[5], 1);
    chk("R8 parent_lo", parent_lo, 1);
    // R5 write one to clear
    clr(24'h000020);
    chk("R5 cleared", pend_q[5], 0);
    chk("R8 parent_lo low", parent_lo, 0);

    // R6 high level on pin 10, word 1
    set_pin(10, 2, 3'b001);
    wr_mask(24'hFFFBD0);
    pin_in[10] = 1'b1;
    cyc(4);
    chk("R6 level pend", pend_q[10], 1);
    chk("R8 parent_hi", parent_hi, 1);
    clr(24'h000400);
    chk("R6 reasserted", pend_q[10], 1);
    pin_in[10] = 1'b0;
    cyc(4);
    clr(24'h000400);
    chk("R6 cleared after level gone", pend_q[10], 0);

    // R3 pin 12 not in interrupt mode
    set_pin(12, 1, 3'b110);
    wr_mask(24'hFFEBD0);
    pin_in[12] = 1'b1; cyc(3); pin_in[12] = 1'b0; cyc(4);
    chk("R3 no pend when function off", pend_q[12], 0);
    chk("R3 parent_hi quiet", parent_hi, 0);

    // R7 masked falling pin 20, word 2
    set_pin(20, 2, 3'b010);
    pin_in[20] = 1'b1; cyc(4);
    pin_in[20] = 1'b0; cyc(3);
    chk("R7 pend latched while masked", pend_q[20], 1);
    chk("R7 parent blocked", parent_hi, 0);
    wr_mask(24'hEFEBD0);
    chk("R8 parent after unmask", parent_hi, 1);
    clr(24'h100000);

    // R1 both edges on pin 9
    set_pin(9, 2, 3'b111);
    pin_in[9] = 1'b1; cyc(3);
    chk("R1 both rise", pend_q[9], 1);
    clr(24'h000200); cyc(1);
    chk("R1 no event while steady", pend_q[9], 0);
    pin_in[9] = 1'b0; cyc(3);
    chk("R1 both fall", pend_q[9], 1);
    clr(24'h000200);

    // R2 pin 15 field at bits 62:60, spare bit 63 set
    trig_cfg[63] = 1'b1;
    set_pin(15, 2, 3'b101);
    pin_in[15] = 1'b1; cyc(3);
    chk("R2 pin15 rising", pend_q[15], 1);
    clr(24'h008000);

    // R9 direct pin 0 low level, pin 1 rising pulse
    set_pin(0, 2, 3'b000);
    cyc(1);
    chk("R9 low level direct", direct_req[0], 1);
    pin_in[0] = 1'b1; cyc(2);
    chk("R9 still low in sync", direct_req[0], 1);
    cyc(1);
    chk("R9 level released", direct_req[0], 0);
    set_pin(1, 2, 3'b100);
    pin_in[1] = 1'b1; cyc(2);
    chk("R9 pulse not yet", direct_req[1], 0);
    cyc(1);
    chk("R9 pulse", direct_req[1], 1);
    cyc(1);
    chk("R9 pulse one cycle", direct_req[1], 0);

    // R10 low bits inert
    wr_mask(24'hFFFFFF);
    chk("R10 mask low bits", mask_q[3:0], 0);
    clr(24'h00000F);
    chk("R10 pend low bits", pend_q[3:0], 0);
    chk("R7 all masked", {parent_lo, parent_hi}, 0);

    cyc(2);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule